// File: doc/BRIEF.md
# Encoded Transition Array Walker

This block finds the longest matching prefix for a name whose components are already encoded. Each component arrives as a pair: a collision-set ID and a local code. The trie is stored as one flat array. Each element records a valid bit, the collision-set ID of the edge that leads into it, the base address of the child node's edges, a prefix-end flag and a next-hop value. Each step takes one combinational read, at the current base plus the code. The step is taken only when that element is valid, lies inside the array and carries the same collision-set ID as the incoming pair.

The walk starts at base address 0 for every name. Once one step fails, the walk is over, and the remaining pairs of that name are ignored. The walk also ends when a pair is flagged as a component that missed in the hash table. When the pair marked last has been consumed, the block reports the deepest prefix-end element reached, or no-match. Between lookups, a write port can rewrite any element. This is how incremental inserts and deletes are applied.

Top module: `eta_walker`

## Requirements
- R1: After reset `res_valid` is 0 and every array element is invalid, so any lookup returns no-match until elements are written.
- R2: A pair (cs, code) read at base O addresses element O+code; the base of the first pair of every name is 0, and an accepted step moves the base to the element's child field.
- R3: A step whose element holds a collision-set ID different from the pair's `in_csid` fails.
- R4: A step whose element has its valid bit clear fails.
- R5: A step whose address O+code is at or above DEPTH fails.
- R6: The result is the prefix-end element reached deepest along accepted steps; a later failure keeps the shallower prefix already found.
- R7: After a failed step, the remaining pairs of the same name have no effect on the result, even when they would match from the stale base.
- R8: A pair with `in_miss`=1 fails at that point, whatever its ID and code.
- R9: The result appears on the clock edge after the last pair is accepted, as a one-cycle `res_valid` pulse; on no-match `res_hit`=0 and `res_hop`=0.
- R10: A write with `wr_en`=1 replaces all fields of element `wr_addr` from the next cycle on; writing `wr_vld`=0 deletes the element.
- R11: Names may follow each other with no idle cycle; each starts again from base 0 with no prefix recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Pair present this cycle |
| in_csid | input | CSID_W | Collision-set ID of the component |
| in_code | input | CODE_W | Local code of the component |
| in_miss | input | 1 | Component was absent from the hash table |
| in_last | input | 1 | Pair is the final one of the name |
| wr_en | input | 1 | Write one array element |
| wr_addr | input | ADDR_W | Element address to write |
| wr_vld | input | 1 | Valid bit to store |
| wr_csid | input | CSID_W | Collision-set ID to store |
| wr_child | input | ADDR_W | Child base address to store |
| wr_pfx | input | 1 | Prefix-end flag to store |
| wr_hop | input | HOP_W | Next-hop value to store |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | A prefix was matched |
| res_hop | output | HOP_W | Next hop of the longest prefix, 0 on no-match |

## Verification
Every pair is consumed at the edge where it is presented. The result registers load at the edge that takes the last pair, so the result is due one cycle after that pair. The bench drives inputs on falling edges and reads the result on the falling edge that follows the last pair. It checks one falling edge later that the pulse has dropped. Element writes take effect one cycle after they are presented, so each write completes before the first pair of the next lookup. The back-to-back case reads the first name's result on the same falling edge where the second name's first pair is driven.

// File: rtl/eta_walker.sv
module eta_walker #(
  parameter int DEPTH  = 48,
  parameter int CSID_W = 4,
  parameter int CODE_W = 4,
  parameter int HOP_W  = 4,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CSID_W-1:0] in_csid,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_miss,
  input  logic              in_last,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_vld,
  input  logic [CSID_W-1:0] wr_csid,
  input  logic [ADDR_W-1:0] wr_child,
  input  logic              wr_pfx,
  input  logic [HOP_W-1:0]  wr_hop,
  output logic              res_valid,
  output logic              res_hit,
  output logic [HOP_W-1:0]  res_hop
);
  localparam int SUM_W = ADDR_W + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(DEPTH);

  logic [CSID_W-1:0] csid_m  [DEPTH];
  logic [ADDR_W-1:0] child_m [DEPTH];
  logic              pfx_m   [DEPTH];
  logic [HOP_W-1:0]  hop_m   [DEPTH];
  logic [DEPTH-1:0]  vld_q;

  logic [ADDR_W-1:0] cur_off;
  logic              alive, best_hit;
  logic [HOP_W-1:0]  best_hop;

  wire [SUM_W-1:0]  sum     = {1'b0, cur_off} + SUM_W'(in_code);
  wire              inrange = sum < LIMIT;
  wire [ADDR_W-1:0] idx     = sum[ADDR_W-1:0];
  wire              step_ok = alive && !in_miss && inrange && vld_q[idx] && (csid_m[idx] == in_csid);
  wire              pfx_now = step_ok && pfx_m[idx];
  wire              nx_hit  = best_hit || pfx_now;
  wire [HOP_W-1:0]  nx_hop  = pfx_now ? hop_m[idx] : best_hop;
  wire              wr_ok   = wr_en && ({1'b0, wr_addr} < LIMIT);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      csid_m[wr_addr]  <= wr_csid;
      child_m[wr_addr] <= wr_child;
      pfx_m[wr_addr]   <= wr_pfx;
      hop_m[wr_addr]   <= wr_hop;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (wr_ok) vld_q[wr_addr] <= wr_vld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_off <= '0; alive <= 1'b1; best_hit <= 1'b0; best_hop <= '0;
      res_valid <= 1'b0; res_hit <= 1'b0; res_hop <= '0;
    end else begin
      res_valid <= in_valid && in_last;
      if (in_valid) begin
        if (in_last) begin
          res_hit  <= nx_hit;
          res_hop  <= nx_hit ? nx_hop : '0;
          cur_off  <= '0;
          alive    <= 1'b1;
          best_hit <= 1'b0;
          best_hop <= '0;
        end else begin
          cur_off  <= step_ok ? child_m[idx] : cur_off;
          alive    <= step_ok;
          best_hit <= nx_hit;
          best_hop <= nx_hop;
        end
      end
    end
  end

  AST_PULSE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid && in_last)); // R9
  AST_NOHIT_ZERO_HOP: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (res_hop == '0)); // R9
  AST_MISS_ENDS_WALK: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_miss && in_last && !best_hit) |=> (res_valid && !res_hit)); // R8
  AST_RANGE_FAIL: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !inrange && in_last && !best_hit) |=> !res_hit); // R5
  AST_ROOT_RESTART: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> (cur_off == '0 && alive && !best_hit)); // R11
  AST_DEAD_STAYS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_last && !alive) |=> !alive); // R7
endmodule

// File: tb/tb_eta_walker.sv
module tb_eta_walker;
  localparam int CLK_P = 10;
  localparam int DEPTH = 48, CSID_W = 4, CODE_W = 4, HOP_W = 4;
  localparam int ADDR_W = $clog2(DEPTH);

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_miss = 0, in_last = 0;
  logic [CSID_W-1:0] in_csid = '0;
  logic [CODE_W-1:0] in_code = '0;
  logic wr_en = 0, wr_vld = 0, wr_pfx = 0;
  logic [ADDR_W-1:0] wr_addr = '0, wr_child = '0;
  logic [CSID_W-1:0] wr_csid = '0;
  logic [HOP_W-1:0] wr_hop = '0;
  logic res_valid, res_hit;
  logic [HOP_W-1:0] res_hop;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  eta_walker #(.DEPTH(DEPTH), .CSID_W(CSID_W), .CODE_W(CODE_W), .HOP_W(HOP_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_csid(in_csid), .in_code(in_code),
    .in_miss(in_miss), .in_last(in_last), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_vld(wr_vld), .wr_csid(wr_csid), .wr_child(wr_child), .wr_pfx(wr_pfx),
    .wr_hop(wr_hop), .res_valid(res_valid), .res_hit(res_hit), .res_hop(res_hop));

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(int a, bit v, int cs, int ch, bit p, int h);
    @(negedge clk);
    wr_en = 1; wr_addr = ADDR_W'(a); wr_vld = v; wr_csid = CSID_W'(cs);
    wr_child = ADDR_W'(ch); wr_pfx = p; wr_hop = HOP_W'(h);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic push(int cs, int code, bit miss, bit last);
    @(negedge clk);
    in_valid = 1; in_csid = CSID_W'(cs); in_code = CODE_W'(code);
    in_miss = miss; in_last = last;
  endtask

  task automatic finish_name(string tag, bit hit, int hop);
    @(negedge clk);
    in_valid = 0; in_last = 0; in_miss = 0;
    check({tag, " valid"}, int'(res_valid), 1);
    check({tag, " hit"}, int'(res_hit), int'(hit));
    check({tag, " hop"}, int'(res_hop), hop);
    @(negedge clk);
    check({tag, " pulse drop"}, int'(res_valid), 0);
  endtask

  task automatic build_table();
    wr(3, 1, 0, 10, 1, 5);
    wr(1, 1, 2, 20, 0, 0);
    wr(12, 1, 1, 30, 1, 7);
    wr(30, 1, 5, 40, 0, 0);
    wr(22, 1, 3, 0, 1, 9);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset res_valid", int'(res_valid), 0);
    push(0, 3, 0, 1);
    finish_name("R1 empty array", 0, 0);
  endtask

  task automatic t_single();
    push(0, 3, 0, 1);
    finish_name("R2 root step", 1, 5);
  endtask

  task automatic t_deeper();
    push(0, 3, 0, 0); push(1, 2, 0, 1);
    finish_name("R6 deeper prefix", 1, 7);
    push(2, 1, 0, 0); push(3, 2, 0, 1);
    finish_name("R2 child base", 1, 9);
  endtask

  task automatic t_range();
    push(0, 3, 0, 0); push(1, 2, 0, 0); push(5, 0, 0, 0); push(0, 10, 0, 1);
    finish_name("R5 out of range keeps R6 shallower", 1, 7);
  endtask

  task automatic t_csid();
    push(0, 3, 0, 0); push(9, 2, 0, 1);
    finish_name("R3 csid mismatch", 1, 5);
    push(4, 3, 0, 1);
    finish_name("R3 root mismatch", 0, 0);
  endtask

  task automatic t_invalid();
    push(0, 3, 0, 0); push(1, 4, 0, 1);
    finish_name("R4 invalid element", 1, 5);
  endtask

  task automatic t_dead();
    push(0, 3, 0, 0); push(9, 2, 0, 0); push(1, 2, 0, 1);
    finish_name("R7 pairs after failure", 1, 5);
  endtask

  task automatic t_miss();
    push(0, 3, 0, 0); push(1, 2, 1, 1);
    finish_name("R8 miss flag mid", 1, 5);
    push(0, 3, 1, 0); push(1, 2, 0, 1);
    finish_name("R8 miss flag first", 0, 0);
  endtask

  task automatic t_write();
    wr(12, 0, 1, 30, 1, 7);
    push(0, 3, 0, 0); push(1, 2, 0, 1);
    finish_name("R10 deleted element", 1, 5);
    wr(12, 1, 1, 30, 1, 11);
    push(0, 3, 0, 0); push(1, 2, 0, 1);
    finish_name("R10 rewritten element", 1, 11);
  endtask

  task automatic t_b2b();
    push(9, 3, 0, 1);
    push(0, 3, 0, 1);
    check("R11 first valid", int'(res_valid), 1);
    check("R11 first no-match hit", int'(res_hit), 0);
    check("R9 no-match hop zero", int'(res_hop), 0);
    push(2, 1, 0, 0);
    check("R11 second valid", int'(res_valid), 1);
    check("R11 second hop", int'(res_hop), 5);
    push(3, 2, 0, 1);
    check("R9 no pulse mid-name", int'(res_valid), 0);
    finish_name("R11 third from root", 1, 9);
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    build_table();
    t_single();
    t_deeper();
    t_range();
    t_csid();
    t_invalid();
    t_dead();
    t_miss();
    t_write();
    t_b2b();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      report();
    end
  end
endmodule